// File: doc/BRIEF.md
# LCD Frame Clock Generator

This block turns one of two slow reference tick streams into the frame-rate enable pulse that drives a segment LCD waveform generator. Software sets a 16-bit control word through a small synchronous register port. The word holds four things: a linear divisor, a power-of-two prescale exponent, a source choice, and the display mode settings. The display mode settings are the number of common phases, segment gating, the low-power waveform flag and the master run bit. The block passes these settings on to the downstream waveform logic. It also keeps a common-phase index that steps on each frame pulse and marks the start of each full frame.

Both reference sources arrive as single-cycle tick enables in the system clock domain. The block selects one of them and runs it through two stages. The first is a linear stage that divides by (divisor + 1). The second is a power-of-two stage that divides by 2^exponent. Exponent codes above 5 act as 5. The settings that affect timing are locked while the block runs. Software must clear the run bit before it changes them, so the counters never see a ratio change in the middle of a period.

Top module: `lfc_frame_gen`

## Requirements
- R1: After reset, the control word reads 0x0000. frameTick, frameStart, segEnable and lcdOn are 0, and phaseIdx is 0.
- R2: The control word is read at address 0 with this layout: bits 15:11 divisor, bits 10:8 exponent, bit 7 source select, bit 6 reserved, bits 5:3 mux code, bit 2 segment-on, bit 1 low-power, bit 0 run. Bit 6 always reads 0. Any other address reads 0x0000.
- R3: While the stored run bit is 1, a write updates only bit 0 (run) and bit 2 (segment-on). Bits 15:7, 5:3 and 1 keep their old values. While the run bit is 0, a write updates every writable field.
- R4: With source 0 ticking every cycle, the first frameTick appears N cycles after the edge that sets the run bit, where N = (divisor+1)·2^exponent. After that, frameTick repeats every N selected ticks.
- R5: Exponent codes 6 and 7 give the same ratio as code 5, which is divide by 32.
- R6: Source select 0 counts srcTickA and source select 1 counts srcTickB.
- R7: While the run bit is 0, no frameTick is produced and phaseIdx returns to 0 one cycle after the run bit clears.
- R8: phaseIdx starts at 0. Each frameTick advances it by one, and after it reaches the mux code it wraps to 0. frameStart is high exactly on the frameTick cycles where phaseIdx becomes 0, so with mux code 0 every frameTick is also a frameStart.
- R9: segEnable equals run AND segment-on. Clearing segment-on leaves frameTick running. muxRate and lowPower show the stored fields.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Register write strobe |
| addr | input | ADDR_W | Register address for write and read |
| wrData | input | 16 | Write data |
| rdData | output | 16 | Read data for addr |
| srcTickA | input | 1 | Primary slow reference tick |
| srcTickB | input | 1 | Internal very-low-frequency oscillator tick |
| frameTick | output | 1 | One-cycle frame-rate enable |
| frameStart | output | 1 | Marks the frameTick that begins a new frame |
| phaseIdx | output | 3 | Active common phase |
| muxRate | output | 3 | Stored mux code (phases per frame minus one) |
| lowPower | output | 1 | Stored low-power waveform flag |
| segEnable | output | 1 | Segments driven (run and segment-on) |
| lcdOn | output | 1 | Stored run bit |

## Verification
A wrong linear or prescale count shows up at frameTick within one frame period. It appears as a first pulse that is early or late against (divisor+1)·2^exponent, or as a steady period that is off. A bad clamp of the exponent codes shows up as a period that is half of, or double, 1024 cycles. A phase counter that wraps at the wrong value or does not clear shows up within mux+2 frame pulses as a phaseIdx or frameStart mismatch. A leak through the write lock shows up on the very next readback of the control word.

// File: rtl/lfc_pkg.sv
package lfc_pkg;
  localparam int DIV_W     = 5;
  localparam int PRE_W     = 3;
  localparam int MUX_W     = 3;
  localparam int REG_W     = 16;
  localparam int PRE_CLAMP = 5;
  localparam int PCNT_W    = PRE_CLAMP;

  // bit positions of the control word (decoded by software)
  localparam int RUN_BIT  = 0;
  localparam int LP_BIT   = 1;
  localparam int SEG_BIT  = 2;
  localparam int MUX_LO   = 3;
  localparam int RESV_BIT = 6;
  localparam int SRC_BIT  = 7;
  localparam int PRE_LO   = 8;
  localparam int DIV_LO   = 11;

  typedef struct packed {
    logic              run;
    logic              srcSel;
    logic [DIV_W-1:0]  divVal;
    logic [PRE_W-1:0]  preExp;
    logic [MUX_W-1:0]  muxVal;
  } ctrlBus_t;

  function automatic logic [PRE_W-1:0] clampPre(input logic [PRE_W-1:0] code);
    if (int'(code) > PRE_CLAMP) return PRE_W'(PRE_CLAMP);
    return code;
  endfunction

  function automatic logic [PCNT_W-1:0] preLimit(input logic [PRE_W-1:0] expo);
    int unsigned v;
    v = (32'd1 << expo) - 32'd1;
    return v[PCNT_W-1:0];
  endfunction
endpackage

// File: rtl/lfc_ctrl_regs.sv
module lfc_ctrl_regs
  import lfc_pkg::*;
#(
  parameter int ADDR_W    = 4,
  parameter int CTRL_ADDR = 0
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                wrEn,
  input  logic [ADDR_W-1:0]   addr,
  input  logic [REG_W-1:0]    wrData,
  output logic [REG_W-1:0]    rdData,
  output ctrlBus_t            ctrlBus,
  output logic                segOn,
  output logic                lowPwr
);
  logic [DIV_W-1:0] divQ;
  logic [PRE_W-1:0] preQ;
  logic [MUX_W-1:0] muxQ;
  logic             srcQ, lpQ, segQ, runQ;
  logic             hit;
  logic             unusedResv;

  assign hit        = (addr == ADDR_W'(CTRL_ADDR));
  assign unusedResv = wrData[RESV_BIT];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      divQ <= '0;
      preQ <= '0;
      muxQ <= '0;
      srcQ <= 1'b0;
      lpQ  <= 1'b0;
      segQ <= 1'b0;
      runQ <= 1'b0;
    end else if (wrEn && hit) begin
      runQ <= wrData[RUN_BIT];
      segQ <= wrData[SEG_BIT];
      if (!runQ) begin
        divQ <= wrData[DIV_LO +: DIV_W];
        preQ <= wrData[PRE_LO +: PRE_W];
        muxQ <= wrData[MUX_LO +: MUX_W];
        srcQ <= wrData[SRC_BIT];
        lpQ  <= wrData[LP_BIT];
      end
    end
  end

  always_comb begin
    rdData = '0;
    if (hit) begin
      rdData[DIV_LO +: DIV_W] = divQ;
      rdData[PRE_LO +: PRE_W] = preQ;
      rdData[SRC_BIT]         = srcQ;
      rdData[MUX_LO +: MUX_W] = muxQ;
      rdData[SEG_BIT]         = segQ;
      rdData[LP_BIT]          = lpQ;
      rdData[RUN_BIT]         = runQ;
    end
  end

  always_comb begin
    ctrlBus.run    = runQ;
    ctrlBus.srcSel = srcQ;
    ctrlBus.divVal = divQ;
    ctrlBus.preExp = clampPre(preQ);
    ctrlBus.muxVal = muxQ;
  end

  assign segOn  = segQ;
  assign lowPwr = lpQ;
endmodule

// File: rtl/lfc_frame_div.sv
module lfc_frame_div
  import lfc_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  ctrlBus_t          ctrlBus,
  input  logic              srcTickA,
  input  logic              srcTickB,
  output logic              frameTick,
  output logic              frameStart,
  output logic [MUX_W-1:0]  phaseIdx
);
  logic [DIV_W-1:0]  divCnt;
  logic [PCNT_W-1:0] preCnt;
  logic [MUX_W-1:0]  phaseQ;
  logic              tickQ, startQ;
  logic              selTick, tick, divWrap, preWrap, phaseWrap;

  assign selTick   = ctrlBus.srcSel ? srcTickB : srcTickA;
  assign tick      = ctrlBus.run && selTick;
  assign divWrap   = (divCnt == ctrlBus.divVal);
  assign preWrap   = (preCnt == preLimit(ctrlBus.preExp));
  assign phaseWrap = (phaseQ == ctrlBus.muxVal);

  always_ff @(posedge clk) begin
    if (!rstN || !ctrlBus.run) begin
      divCnt <= '0;
      preCnt <= '0;
      phaseQ <= '0;
      tickQ  <= 1'b0;
      startQ <= 1'b0;
    end else begin
      tickQ  <= 1'b0;
      startQ <= 1'b0;
      if (tick) begin
        if (divWrap) begin
          divCnt <= '0;
          if (preWrap) begin
            preCnt <= '0;
            tickQ  <= 1'b1;
            startQ <= phaseWrap;
            phaseQ <= phaseWrap ? '0 : phaseQ + 1'b1;
          end else begin
            preCnt <= preCnt + 1'b1;
          end
        end else begin
          divCnt <= divCnt + 1'b1;
        end
      end
    end
  end

  assign frameTick  = tickQ;
  assign frameStart = startQ;
  assign phaseIdx   = phaseQ;
endmodule

// File: rtl/lfc_frame_gen.sv
module lfc_frame_gen
  import lfc_pkg::*;
#(
  parameter int ADDR_W    = 4,
  parameter int CTRL_ADDR = 0
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic [15:0]       wrData,
  output logic [15:0]       rdData,
  input  logic              srcTickA,
  input  logic              srcTickB,
  output logic              frameTick,
  output logic              frameStart,
  output logic [2:0]        phaseIdx,
  output logic [2:0]        muxRate,
  output logic              lowPower,
  output logic              segEnable,
  output logic              lcdOn
);
  ctrlBus_t ctrlBus;
  logic     segOn;

  lfc_ctrl_regs #(.ADDR_W(ADDR_W), .CTRL_ADDR(CTRL_ADDR)) u_regs (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .addr(addr), .wrData(wrData),
    .rdData(rdData), .ctrlBus(ctrlBus), .segOn(segOn), .lowPwr(lowPower)
  );

  lfc_frame_div u_div (
    .clk(clk), .rstN(rstN), .ctrlBus(ctrlBus),
    .srcTickA(srcTickA), .srcTickB(srcTickB),
    .frameTick(frameTick), .frameStart(frameStart), .phaseIdx(phaseIdx)
  );

  assign muxRate   = ctrlBus.muxVal;
  assign lcdOn     = ctrlBus.run;
  assign segEnable = ctrlBus.run && segOn;
endmodule

// File: rtl/lfc_frame_gen_chk.sv
module lfc_frame_gen_chk (
  input logic       clk,
  input logic       rstN,
  input logic       frameTick,
  input logic       frameStart,
  input logic [2:0] phaseIdx,
  input logic [2:0] muxRate,
  input logic       lowPower,
  input logic       segEnable,
  input logic       lcdOn,
  input logic       resvBit
);
  // R7
  idle_no_tick_chk: assert property (@(posedge clk) disable iff (!rstN)
    !$past(lcdOn) |-> !frameTick);
  // R7
  idle_phase_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    !$past(lcdOn) |-> phaseIdx == 3'd0);
  // R8
  start_with_tick_chk: assert property (@(posedge clk) disable iff (!rstN)
    frameStart |-> frameTick);
  // R8
  phase_range_chk: assert property (@(posedge clk) disable iff (!rstN)
    phaseIdx <= muxRate);
  // R8
  phase_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    ($past(lcdOn) && !frameTick) |-> $stable(phaseIdx));
  // R3
  locked_fields_chk: assert property (@(posedge clk) disable iff (!rstN)
    $past(lcdOn) |-> ($stable(muxRate) && $stable(lowPower)));
  // R9
  seg_gate_chk: assert property (@(posedge clk) disable iff (!rstN)
    segEnable |-> lcdOn);
  // R2
  resv_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    !resvBit);
endmodule

bind lfc_frame_gen lfc_frame_gen_chk u_chk (
  .clk(clk), .rstN(rstN), .frameTick(frameTick), .frameStart(frameStart),
  .phaseIdx(phaseIdx), .muxRate(muxRate), .lowPower(lowPower),
  .segEnable(segEnable), .lcdOn(lcdOn), .resvBit(rdData[6])
);

// File: tb/lfc_frame_gen_tb.sv
`timescale 1ns/1ps
module lfc_frame_gen_tb;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrEn = 1'b0;
  logic [3:0]  addr = '0;
  logic [15:0] wrData = '0;
  logic [15:0] rdData;
  logic        srcTickA = 1'b1;
  logic        srcTickB = 1'b0;
  logic        frameTick, frameStart, lowPower, segEnable, lcdOn;
  logic [2:0]  phaseIdx, muxRate;
  int          nChecks = 0;
  int          nErr = 0;
  int          bCnt = 0;

  always #2.5 clk = ~clk;

  // srcTickB: one tick every third cycle
  always @(negedge clk) begin
    bCnt     <= (bCnt == 2) ? 0 : bCnt + 1;
    srcTickB <= (bCnt == 2);
  end

  lfc_frame_gen u_dut (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .addr(addr), .wrData(wrData),
    .rdData(rdData), .srcTickA(srcTickA), .srcTickB(srcTickB),
    .frameTick(frameTick), .frameStart(frameStart), .phaseIdx(phaseIdx),
    .muxRate(muxRate), .lowPower(lowPower), .segEnable(segEnable), .lcdOn(lcdOn)
  );

  typedef struct packed {
    logic [4:0]  d;
    logic [2:0]  p;
    logic        s;
    logic [2:0]  m;
    logic [15:0] n;
  } vec_t;

  localparam vec_t VECS [8] = '{
    '{5'd0,  3'd0, 1'b0, 3'd0, 16'd1},
    '{5'd4,  3'd0, 1'b0, 3'd3, 16'd5},
    '{5'd2,  3'd3, 1'b0, 3'd1, 16'd24},
    '{5'd31, 3'd0, 1'b0, 3'd7, 16'd32},
    '{5'd1,  3'd6, 1'b0, 3'd2, 16'd64},
    '{5'd0,  3'd7, 1'b0, 3'd0, 16'd32},
    '{5'd3,  3'd2, 1'b1, 3'd4, 16'd16},
    '{5'd31, 3'd5, 1'b0, 3'd5, 16'd1024}
  };

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nErr++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [15:0] d);
    @(negedge clk);
    wrEn = 1'b1; addr = 4'd0; wrData = d;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  function automatic logic [15:0] cfg(input logic [4:0] d, input logic [2:0] p,
      input logic s, input logic [2:0] m, input logic seg, input logic run);
    return {d, p, s, 1'b0, m, seg, 1'b0, run};
  endfunction

  task automatic waitTick(output int cnt);
    cnt = 0;
    do begin
      @(negedge clk);
      cnt++;
    end while (!frameTick && cnt < 5000);
  endtask

  task automatic stepPhase(inout int expPh, input int mux);
    expPh = (expPh == mux) ? 0 : expPh + 1;
    chk(phaseIdx == 3'(expPh), "R8 phase", int'(phaseIdx), expPh);
    chk(frameStart == (expPh == 0), "R8 frameStart", int'(frameStart), int'(expPh == 0));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nErr++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("  CHECKS %0d ERRORS %0d", nChecks, nErr);
    $finish;
  end

  initial begin
    int cnt, expPh, mult;
    repeat (5) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(rdData == 16'h0000, "R1 rdData", int'(rdData), 0);
    chk(!frameTick && !frameStart, "R1 ticks", int'(frameTick), 0);
    chk(phaseIdx == 3'd0, "R1 phase", int'(phaseIdx), 0);
    chk(!segEnable && !lcdOn, "R1 enables", int'(lcdOn), 0);

    // vector table: R4 R5 R6 R8
    for (int i = 0; i < 8; i++) begin
      mult = VECS[i].s ? 3 : 1;
      wr(16'h0000);
      wr(cfg(VECS[i].d, VECS[i].p, VECS[i].s, VECS[i].m, 1'b1, 1'b0));
      wr(cfg(VECS[i].d, VECS[i].p, VECS[i].s, VECS[i].m, 1'b1, 1'b1));
      expPh = 0;
      waitTick(cnt);
      if (!VECS[i].s)
        chk(cnt == int'(VECS[i].n), (VECS[i].p > 3'd5) ? "R5 first pulse" : "R4 first pulse",
            cnt, int'(VECS[i].n));
      stepPhase(expPh, int'(VECS[i].m));
      for (int k = 0; k < int'(VECS[i].m) + 2; k++) begin
        waitTick(cnt);
        chk(cnt == mult * int'(VECS[i].n),
            VECS[i].s ? "R6 period" : "R4 period", cnt, mult * int'(VECS[i].n));
        stepPhase(expPh, int'(VECS[i].m));
      end
    end

    // R2 layout and reserved bit
    wr(16'h0000);
    wr(16'hFFFF);
    chk(rdData == 16'hFFBF, "R2 readback", int'(rdData), 16'hFFBF);
    @(negedge clk); addr = 4'd1; #1;
    chk(rdData == 16'h0000, "R2 other addr", int'(rdData), 0);
    addr = 4'd0;
    // R3 locked fields while running
    wr(16'h0000);
    chk(rdData == 16'hFFBA, "R3 locked", int'(rdData), 16'hFFBA);
    chk(muxRate == 3'd7 && lowPower, "R3 outputs", int'(muxRate), 7);
    wr(16'h0000);
    chk(rdData == 16'h0000, "R3 unlocked", int'(rdData), 0);

    // R7 no pulses while stopped (fastest ratio configured)
    wr(cfg(5'd0, 3'd0, 1'b0, 3'd3, 1'b1, 1'b0));
    cnt = 0;
    for (int k = 0; k < 40; k++) begin
      @(negedge clk);
      if (frameTick) cnt++;
    end
    chk(cnt == 0, "R7 idle ticks", cnt, 0);
    chk(phaseIdx == 3'd0, "R7 idle phase", int'(phaseIdx), 0);

    // R9 segment gating
    wr(cfg(5'd0, 3'd0, 1'b0, 3'd3, 1'b1, 1'b1));
    chk(segEnable, "R9 seg on", int'(segEnable), 1);
    wr(cfg(5'd0, 3'd0, 1'b0, 3'd3, 1'b0, 1'b1));
    chk(!segEnable, "R9 seg off", int'(segEnable), 0);
    cnt = 0;
    for (int k = 0; k < 8; k++) begin
      @(negedge clk);
      if (frameTick) cnt++;
    end
    chk(cnt == 8, "R9 ticks continue", cnt, 8);
    wr(cfg(5'd0, 3'd0, 1'b0, 3'd3, 1'b1, 1'b0));
    chk(!segEnable && !lcdOn, "R9 stopped", int'(segEnable), 0);
    @(negedge clk);
    chk(phaseIdx == 3'd0 && !frameTick, "R7 stop clears", int'(phaseIdx), 0);

    $display("  CHECKS %0d ERRORS %0d", nChecks, nErr);
    $finish;
  end
endmodule